// File: doc/BRIEF.md
# Hashed Exact-Match MAC Filter Table

This block keeps a table of destination-MAC filter entries and answers lookups against it. Each entry is keyed by a 48-bit MAC address, a 12-bit channel number and a 2-bit channel type. The three fields are packed into a 62-bit key and ANDed with a configuration mask. The result is hashed with CRC-32 to pick a row of a four-way set-associative memory. When all four ways of that row are in use, the entry is placed in a small fully associative overflow CAM instead.

Software-side agents drive a valid/ready command port. There are three commands:
- insert a key;
- delete the entry at a given location (table, way, index);
- replace the key held at a location.

Each command finishes with a one-cycle done pulse that carries a status code and the location it used. An independent lookup port compares a key against the four ways of its hashed row and against every CAM entry in the same cycle. It returns a registered hit/miss, table type, way and index one cycle later.

Top module: `mac_match_table`

## Requirements
- R1: The key is {ctype[1:0], chan[11:0], mac[47:0]} (ctype in bits 61:60, channel in 59:48, MAC in 47:0), ANDed with `key_mask`. The stored entry word is the masked key shifted left by 2. The default mask has bits 59:0 set and bits 61:60 clear, so by default channel type has no effect on matching.
- R2: The row index is the low log2(ROWS) bits of a CRC-32 over the 64-bit masked key, computed as follows. Use polynomial 0x04C11DB7 with initial value 0, no reflection and no final XOR. Process the bits from bit 63 down to bit 0. For each bit, the feedback is crc[31] XOR the data bit; shift crc left by one; if the feedback is 1, XOR in the polynomial. The row offset is 0. A ROWS value that is not a power of two (or is below 2) is an elaboration error.
- R3: Insert (op 0) places the entry in the lowest-numbered free way of the hashed row. It reports status 0 (OK), table 0 (memory), that way, and the row as index.
- R4: If all four ways of the hashed row are occupied, insert uses the lowest-numbered free CAM slot. It reports status 0, table 1 (CAM), way 0, and the slot as index.
- R5: If the row and the CAM are both full, insert reports status 1 (no space) and stores nothing.
- R6: A lookup presented with `lk_valid` yields `res_valid` and the result fields on the next cycle. `res_hit` is 1 only when an occupied slot holds the lookup's masked, shifted key; otherwise it is 0.
- R7: When a key is present both in the hashed memory and in the CAM, the lookup reports the memory entry. Within the memory the lowest way wins; within the CAM the lowest slot wins.
- R8: Delete (op 1) of an occupied location writes an all-zero word there, frees the slot and reports status 0. Later lookups no longer hit it, and a later insert may reuse it. Delete of an empty or out-of-range location reports status 2 (not found).
- R9: Update (op 2) of an occupied CAM slot, or of an occupied memory slot whose new key hashes to the same row, rewrites the key and reports status 0. A memory update whose new key hashes to a different row reports status 3 (index mismatch) and leaves the entry unchanged. An update of an empty slot reports status 2.
- R10: A command is accepted when `cmd_valid` and `cmd_ready` are both high. `rsp_done` pulses for exactly one cycle on the next cycle, and `cmd_ready` is low during that pulse. Op 3 completes with status 2 and changes nothing.
- R11: After reset every slot is empty, `cmd_ready` is 1, and `rsp_done` and `res_hit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_mask | input | 62 | Mask ANDed with the packed key |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 2 | 0 insert, 1 delete, 2 update, 3 reserved |
| cmd_mac | input | 48 | MAC for insert/update |
| cmd_chan | input | 12 | Channel for insert/update |
| cmd_ctype | input | 2 | Channel type for insert/update |
| cmd_tbl | input | 1 | Target table for delete/update (0 memory, 1 CAM) |
| cmd_way | input | 2 | Target way for delete/update in memory |
| cmd_index | input | IDX_W | Target row or CAM slot for delete/update |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | 0 OK, 1 no space, 2 not found, 3 index mismatch |
| rsp_tbl | output | 1 | Table of the location used |
| rsp_way | output | 2 | Way of the location used |
| rsp_index | output | IDX_W | Row or slot of the location used |
| lk_valid | input | 1 | Lookup request |
| lk_mac | input | 48 | Lookup MAC |
| lk_chan | input | 12 | Lookup channel |
| lk_ctype | input | 2 | Lookup channel type |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Lookup found the key |
| res_tbl | output | 1 | Table of the hit |
| res_way | output | 2 | Way of the hit (0 for CAM) |
| res_index | output | IDX_W | Row or CAM slot of the hit |

## Verification
The assertions check the following on every cycle:
- every accepted command gets exactly one done pulse;
- a CAM placement reports way 0;
- an index mismatch only ever concerns a memory entry;
- no-space is never reported while the hashed row or the CAM still has a free slot;
- a CAM hit always points at an occupied slot;
- clearing a slot writes zero.

The way-fill order, the CAM overflow order, memory-over-CAM priority, the effect of the channel-type mask, and whether a refused update really left the old key in place can only be shown by the bench's scenarios. The bench reaches these by searching for keys that collide on one row.

// File: rtl/mmt_pkg.sv
// Package: shared types and key/hash helpers for the MAC match table.
// Assumes a 62-bit packed key and a 64-bit stored entry word.
package mmt_pkg;

    localparam int MAC_W  = 48;
    localparam int CHAN_W = 12;
    localparam int CTYP_W = 2;
    localparam int KEY_W  = MAC_W + CHAN_W + CTYP_W;
    localparam int WORD_W = 64;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [KEY_W-1:0] MASK_DEFAULT = {2'b00, 60'hFFF_FFFF_FFFF_FFFF};

    typedef enum logic [1:0] {
        OP_INSERT = 2'd0,
        OP_DELETE = 2'd1,
        OP_UPDATE = 2'd2,
        OP_RSVD   = 2'd3
    } mmt_op_e;

    typedef enum logic [1:0] {
        ST_OK       = 2'd0,
        ST_NOSPACE  = 2'd1,
        ST_NOTFOUND = 2'd2,
        ST_MISMATCH = 2'd3
    } mmt_status_e;

    localparam logic TBL_MEM = 1'b0;
    localparam logic TBL_CAM = 1'b1;

    // Pack and mask the key fields into a 64-bit word (top two bits zero).
    function automatic logic [WORD_W-1:0] masked_key(
        input logic [MAC_W-1:0]  mac,
        input logic [CHAN_W-1:0] chan,
        input logic [CTYP_W-1:0] ctype,
        input logic [KEY_W-1:0]  mask);
        return {2'b00, ({ctype, chan, mac} & mask)};
    endfunction

    // CRC-32, MSB first, zero initial value, no reflection, no final XOR.
    function automatic logic [31:0] crc32_word(input logic [WORD_W-1:0] d);
        logic [31:0] c;
        logic        fb;
        c = '0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb = c[31] ^ d[i];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/mmt_hash.sv
// Module: mmt_hash
// Maps a masked key word to a row of the hashed memory.
// Assumes the row count is a power of two, so the AND with (rows-1)
// is a plain bit slice; the row offset is zero.
module mmt_hash #(
    parameter int ROW_W = 8
) (
    input  logic [mmt_pkg::WORD_W-1:0] key_in,
    output logic [ROW_W-1:0]           row
);
    logic [31:0] crc;

    // Hash the key and keep the low bits as the row.
    always_comb begin
        crc = mmt_pkg::crc32_word(key_in);
        row = crc[ROW_W-1:0];
    end
endmodule

// File: rtl/mmt_bank.sv
// Module: mmt_bank
// One way of the hashed memory: a data word and an occupancy bit per row.
// Port A reads occupancy for the command path; port B reads occupancy and
// data for the lookup path. Data is not reset; occupancy gates every use.
module mmt_bank #(
    parameter int ROWS  = 256,
    parameter int ROW_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ROW_W-1:0]           wr_row,
    input  logic [mmt_pkg::WORD_W-1:0] wr_data,
    input  logic                       wr_set,
    input  logic [ROW_W-1:0]           a_row,
    output logic                       a_occ,
    input  logic [ROW_W-1:0]           b_row,
    output logic                       b_occ,
    output logic [mmt_pkg::WORD_W-1:0] b_data
);
    logic [mmt_pkg::WORD_W-1:0] mem [ROWS];
    logic [ROWS-1:0]            occ;

    // Occupancy: cleared by reset, set or cleared by a write.
    always_ff @(posedge clk) begin
        if (!rst_n) occ <= '0;
        else if (wr_en) occ[wr_row] <= wr_set;
    end

    // Entry data storage.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_row] <= wr_data;
    end

    // Asynchronous read ports.
    always_comb begin
        a_occ  = occ[a_row];
        b_occ  = occ[b_row];
        b_data = mem[b_row];
    end

    AST_CLEAR_WRITES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_set) |-> (wr_data == '0)); // R8
endmodule

// File: rtl/mmt_cam.sv
// Module: mmt_cam
// Fully associative overflow store. Reports the lowest free slot and the
// lowest occupied slot whose word equals the query word.
module mmt_cam #(
    parameter int ENTRIES = 32,
    parameter int CAM_W   = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [CAM_W-1:0]           wr_idx,
    input  logic [mmt_pkg::WORD_W-1:0] wr_data,
    input  logic                       wr_set,
    input  logic [mmt_pkg::WORD_W-1:0] q_word,
    output logic [ENTRIES-1:0]         occ_o,
    output logic                       free_any,
    output logic [CAM_W-1:0]           free_idx,
    output logic                       hit_any,
    output logic [CAM_W-1:0]           hit_idx
);
    logic [mmt_pkg::WORD_W-1:0] ent [ENTRIES];
    logic [ENTRIES-1:0]         occ;

    // Occupancy per slot.
    always_ff @(posedge clk) begin
        if (!rst_n) occ <= '0;
        else if (wr_en) occ[wr_idx] <= wr_set;
    end

    // Slot data.
    always_ff @(posedge clk) begin
        if (wr_en) ent[wr_idx] <= wr_data;
    end

    // Lowest free slot and lowest matching slot.
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        hit_any  = 1'b0;
        hit_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!occ[i]) begin
                free_any = 1'b1;
                free_idx = CAM_W'(i);
            end
            if (occ[i] && (ent[i] == q_word)) begin
                hit_any = 1'b1;
                hit_idx = CAM_W'(i);
            end
        end
        occ_o = occ;
    end

    AST_CAM_HIT_OCCUPIED: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |-> occ_o[hit_idx]); // R6
endmodule

// File: rtl/mac_match_table.sv
// Module: mac_match_table
// Two-level exact-match MAC table: a WAYS-way hashed memory of ROWS rows
// with a fully associative CAM of CAM_N slots for overflow. Commands
// (insert/delete/update) complete one per two cycles; lookups are
// pipelined with one register stage. Assumes ROWS is a power of two.
module mac_match_table #(
    parameter int ROWS  = 256,
    parameter int WAYS  = 4,
    parameter int CAM_N = 32,
    localparam int ROW_W = $clog2(ROWS),
    localparam int CAM_W = $clog2(CAM_N),
    localparam int WAY_W = $clog2(WAYS),
    localparam int IDX_W = (ROW_W > CAM_W) ? ROW_W : CAM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [61:0]       key_mask,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [47:0]       cmd_mac,
    input  logic [11:0]       cmd_chan,
    input  logic [1:0]        cmd_ctype,
    input  logic              cmd_tbl,
    input  logic [WAY_W-1:0]  cmd_way,
    input  logic [IDX_W-1:0]  cmd_index,
    output logic              rsp_done,
    output logic [1:0]        rsp_status,
    output logic              rsp_tbl,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [IDX_W-1:0]  rsp_index,
    input  logic              lk_valid,
    input  logic [47:0]       lk_mac,
    input  logic [11:0]       lk_chan,
    input  logic [1:0]        lk_ctype,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_tbl,
    output logic [WAY_W-1:0]  res_way,
    output logic [IDX_W-1:0]  res_index
);
    import mmt_pkg::*;

    // Configuration check on the row count.
    if (ROWS < 2 || (ROWS & (ROWS - 1)) != 0) begin : g_bad_rows
        $error("mac_match_table: ROWS must be a power of two and at least 2");
    end

    // ---------------- command path signals ----------------
    logic                cmd_fire;
    logic [WORD_W-1:0]   cmd_key, cmd_word;
    logic [ROW_W-1:0]    cmd_hrow, a_row;
    logic [WAYS-1:0]     a_occ;
    logic                fw_any;
    logic [WAY_W-1:0]    fw;
    logic                row_ok, slot_ok;
    logic [WAYS-1:0]     bank_we;
    logic                cam_we;
    logic                wr_set;
    logic [WORD_W-1:0]   wr_word;
    logic [ROW_W-1:0]    wr_row;
    logic [CAM_W-1:0]    cam_wr_idx;
    mmt_status_e         nx_status;
    logic                nx_tbl;
    logic [WAY_W-1:0]    nx_way;
    logic [IDX_W-1:0]    nx_index;

    // ---------------- lookup path signals ----------------
    logic [WORD_W-1:0]   lk_key, lk_word;
    logic [ROW_W-1:0]    lk_row;
    logic [WAYS-1:0]     b_occ;
    logic [WORD_W-1:0]   b_data [WAYS];
    logic                mem_hit;
    logic [WAY_W-1:0]    mem_way;

    // CAM interface
    logic [CAM_N-1:0]    cam_occ;
    logic                cam_free_any, cam_hit_any;
    logic [CAM_W-1:0]    cam_free_idx, cam_hit_idx;

    assign cmd_ready = !rsp_done;
    assign cmd_fire  = cmd_valid && cmd_ready;

    // Build the masked key and stored word for both paths.
    always_comb begin
        cmd_key  = masked_key(cmd_mac, cmd_chan, cmd_ctype, key_mask);
        cmd_word = cmd_key << 2;
        lk_key   = masked_key(lk_mac, lk_chan, lk_ctype, key_mask);
        lk_word  = lk_key << 2;
    end

    mmt_hash #(.ROW_W(ROW_W)) u_hash_cmd (.key_in(cmd_key), .row(cmd_hrow));
    mmt_hash #(.ROW_W(ROW_W)) u_hash_lk  (.key_in(lk_key),  .row(lk_row));

    // Command port A row: hashed row for insert, given row otherwise.
    always_comb begin
        a_row = (mmt_op_e'(cmd_op) == OP_INSERT) ? cmd_hrow : cmd_index[ROW_W-1:0];
    end

    // The hashed memory, one bank per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        mmt_bank #(.ROWS(ROWS), .ROW_W(ROW_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bank_we[w]),
            .wr_row  (wr_row),
            .wr_data (wr_word),
            .wr_set  (wr_set),
            .a_row   (a_row),
            .a_occ   (a_occ[w]),
            .b_row   (lk_row),
            .b_occ   (b_occ[w]),
            .b_data  (b_data[w])
        );
    end

    mmt_cam #(.ENTRIES(CAM_N), .CAM_W(CAM_W)) u_cam (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cam_we),
        .wr_idx   (cam_wr_idx),
        .wr_data  (wr_word),
        .wr_set   (wr_set),
        .q_word   (lk_word),
        .occ_o    (cam_occ),
        .free_any (cam_free_any),
        .free_idx (cam_free_idx),
        .hit_any  (cam_hit_any),
        .hit_idx  (cam_hit_idx)
    );

    // Lowest free way in the command row.
    always_comb begin
        fw_any = 1'b0;
        fw     = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!a_occ[w]) begin
                fw_any = 1'b1;
                fw     = WAY_W'(w);
            end
        end
    end

    // Range and occupancy test of the addressed location.
    always_comb begin
        row_ok  = (32'(cmd_index) < ROWS) && a_occ[cmd_way];
        slot_ok = (32'(cmd_index) < CAM_N) && cam_occ[cmd_index[CAM_W-1:0]];
    end

    // Command decision: which store to write and what to report.
    always_comb begin
        bank_we    = '0;
        cam_we     = 1'b0;
        wr_set     = 1'b0;
        wr_word    = '0;
        wr_row     = cmd_index[ROW_W-1:0];
        cam_wr_idx = cmd_index[CAM_W-1:0];
        nx_status  = ST_NOTFOUND;
        nx_tbl     = cmd_tbl;
        nx_way     = cmd_way;
        nx_index   = cmd_index;
        case (mmt_op_e'(cmd_op))
            OP_INSERT: begin
                wr_set  = 1'b1;
                wr_word = cmd_word;
                wr_row  = cmd_hrow;
                if (fw_any) begin
                    bank_we[fw] = cmd_fire;
                    nx_status   = ST_OK;
                    nx_tbl      = TBL_MEM;
                    nx_way      = fw;
                    nx_index    = IDX_W'(cmd_hrow);
                end else if (cam_free_any) begin
                    cam_we     = cmd_fire;
                    cam_wr_idx = cam_free_idx;
                    nx_status  = ST_OK;
                    nx_tbl     = TBL_CAM;
                    nx_way     = '0;
                    nx_index   = IDX_W'(cam_free_idx);
                end else begin
                    nx_status = ST_NOSPACE;
                    nx_tbl    = TBL_MEM;
                    nx_way    = '0;
                    nx_index  = IDX_W'(cmd_hrow);
                end
            end
            OP_DELETE: begin
                if (cmd_tbl == TBL_MEM && row_ok) begin
                    bank_we[cmd_way] = cmd_fire;
                    nx_status        = ST_OK;
                end else if (cmd_tbl == TBL_CAM && slot_ok) begin
                    cam_we    = cmd_fire;
                    nx_status = ST_OK;
                end
            end
            OP_UPDATE: begin
                wr_set  = 1'b1;
                wr_word = cmd_word;
                if (cmd_tbl == TBL_MEM && row_ok) begin
                    if (cmd_hrow != cmd_index[ROW_W-1:0]) begin
                        nx_status = ST_MISMATCH;
                    end else begin
                        bank_we[cmd_way] = cmd_fire;
                        nx_status        = ST_OK;
                    end
                end else if (cmd_tbl == TBL_CAM && slot_ok) begin
                    cam_we    = cmd_fire;
                    nx_status = ST_OK;
                end
            end
            default: nx_status = ST_NOTFOUND;
        endcase
    end

    // Completion register: one pulse per accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done   <= 1'b0;
            rsp_status <= '0;
            rsp_tbl    <= 1'b0;
            rsp_way    <= '0;
            rsp_index  <= '0;
        end else begin
            rsp_done <= cmd_fire;
            if (cmd_fire) begin
                rsp_status <= nx_status;
                rsp_tbl    <= nx_tbl;
                rsp_way    <= nx_way;
                rsp_index  <= nx_index;
            end
        end
    end

    // Lowest matching way in the lookup row.
    always_comb begin
        mem_hit = 1'b0;
        mem_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (b_occ[w] && (b_data[w] == lk_word)) begin
                mem_hit = 1'b1;
                mem_way = WAY_W'(w);
            end
        end
    end

    // Lookup result register; memory hit beats CAM hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_tbl   <= 1'b0;
            res_way   <= '0;
            res_index <= '0;
        end else begin
            res_valid <= lk_valid;
            res_hit   <= lk_valid && (mem_hit || cam_hit_any);
            if (mem_hit) begin
                res_tbl   <= TBL_MEM;
                res_way   <= mem_way;
                res_index <= IDX_W'(lk_row);
            end else begin
                res_tbl   <= TBL_CAM;
                res_way   <= '0;
                res_index <= IDX_W'(cam_hit_idx);
            end
        end
    end

    AST_DONE_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> rsp_done); // R10
    AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R10
    AST_CAM_REPORTS_WAY0: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_tbl == TBL_CAM && rsp_status == ST_OK) |-> (rsp_way == '0)); // R4
    AST_MISMATCH_MEM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_status == ST_MISMATCH) |-> (rsp_tbl == TBL_MEM)); // R9
    AST_NOSPACE_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && mmt_op_e'(cmd_op) == OP_INSERT && !((&a_occ) && (&cam_occ)))
        |=> (rsp_status != ST_NOSPACE)); // R5
    AST_NO_RESULT_UNASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_hit); // R6
endmodule

// File: tb/mac_match_table_bench.sv
// Directed bench for mac_match_table: one task per scenario.
module mac_match_table_bench;
    localparam int  CLK_PERIOD = 10;
    localparam int  ROWS  = 256;
    localparam int  IDX_W = 8;
    localparam logic [61:0] DEF_MASK = {2'b00, 60'hFFF_FFFF_FFFF_FFFF};
    localparam logic [11:0] CH = 12'h05A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [61:0] key_mask = DEF_MASK;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [1:0] cmd_op = '0;
    logic [47:0] cmd_mac = '0;
    logic [11:0] cmd_chan = '0;
    logic [1:0] cmd_ctype = '0;
    logic cmd_tbl = 1'b0;
    logic [1:0] cmd_way = '0;
    logic [IDX_W-1:0] cmd_index = '0;
    logic rsp_done;
    logic [1:0] rsp_status;
    logic rsp_tbl;
    logic [1:0] rsp_way;
    logic [IDX_W-1:0] rsp_index;
    logic lk_valid = 1'b0;
    logic [47:0] lk_mac = '0;
    logic [11:0] lk_chan = '0;
    logic [1:0] lk_ctype = '0;
    logic res_valid, res_hit, res_tbl;
    logic [1:0] res_way;
    logic [IDX_W-1:0] res_index;

    int n_chk = 0;
    int n_bad = 0;
    logic [47:0] cursor = 48'h02_00_00_00_10_00;
    int row_r;
    logic [47:0] k0, k1, k2, k3, k4, k5, k6, k7, kx;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_match_table u_mac_match_table (
        .clk(clk), .rst_n(rst_n), .key_mask(key_mask),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_mac(cmd_mac), .cmd_chan(cmd_chan), .cmd_ctype(cmd_ctype),
        .cmd_tbl(cmd_tbl), .cmd_way(cmd_way), .cmd_index(cmd_index),
        .rsp_done(rsp_done), .rsp_status(rsp_status), .rsp_tbl(rsp_tbl),
        .rsp_way(rsp_way), .rsp_index(rsp_index),
        .lk_valid(lk_valid), .lk_mac(lk_mac), .lk_chan(lk_chan), .lk_ctype(lk_ctype),
        .res_valid(res_valid), .res_hit(res_hit), .res_tbl(res_tbl),
        .res_way(res_way), .res_index(res_index)
    );

    // Reference row: CRC-32 as written in R2, over the R1 masked key.
    function automatic int ref_row(input logic [47:0] mac, input logic [11:0] ch,
                                   input logic [1:0] ct, input logic [61:0] m);
        logic [63:0] k;
        logic [31:0] c;
        k = {2'b00, ({ct, ch, mac} & m)};
        c = 32'h0;
        for (int b = 63; b >= 0; b--) begin
            if (c[31] ^ k[b]) c = {c[30:0], 1'b0} ^ 32'h04C11DB7;
            else              c = {c[30:0], 1'b0};
        end
        return int'(c[7:0]);
    endfunction

    // Next MAC (channel CH, type 0) whose row is, or is not, the given one.
    task automatic seek(input int row, input bit same, output logic [47:0] m);
        forever begin
            cursor = cursor + 48'd1;
            if ((ref_row(cursor, CH, 2'd0, DEF_MASK) == row) == same) begin
                m = cursor;
                return;
            end
        end
    endtask

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    logic [1:0] got_st;
    logic got_tbl;
    logic [1:0] got_way;
    logic [IDX_W-1:0] got_idx;
    logic got_done;

    task automatic do_cmd(input logic [1:0] op, input logic [47:0] mac, input logic [1:0] ct,
                          input logic tb, input logic [1:0] wy, input int idx);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_mac = mac; cmd_chan = CH; cmd_ctype = ct;
        cmd_tbl = tb; cmd_way = wy; cmd_index = IDX_W'(idx);
        @(negedge clk);
        cmd_valid = 1'b0;
        got_done = rsp_done; got_st = rsp_status; got_tbl = rsp_tbl;
        got_way = rsp_way; got_idx = rsp_index;
        @(negedge clk);
    endtask

    task automatic expect_rsp(input string req, input int st, input int tb, input int wy, input int idx);
        chk(req, "done", longint'(got_done), 1);
        chk(req, "status", longint'(got_st), st);
        chk(req, "table", longint'(got_tbl), tb);
        chk(req, "way", longint'(got_way), wy);
        chk(req, "index", longint'(got_idx), idx);
    endtask

    task automatic look(input string req, input logic [47:0] mac, input logic [11:0] ch,
                        input logic [1:0] ct, input int hit, input int tb, input int wy, input int idx);
        @(negedge clk);
        lk_valid = 1'b1; lk_mac = mac; lk_chan = ch; lk_ctype = ct;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(req, "res_valid", longint'(res_valid), 1);
        chk(req, "res_hit", longint'(res_hit), hit);
        if (hit != 0) begin
            chk(req, "res_tbl", longint'(res_tbl), tb);
            chk(req, "res_way", longint'(res_way), wy);
            chk(req, "res_index", longint'(res_index), idx);
        end
    endtask

    // R11: state after reset.
    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "cmd_ready", longint'(cmd_ready), 1);
        chk("R11", "rsp_done", longint'(rsp_done), 0);
        chk("R11", "res_hit", longint'(res_hit), 0);
        look("R11", k0, CH, 2'd0, 0, 0, 0, 0);
    endtask

    // R3, R2, R10: fill the four ways of one row in order.
    task automatic t_fill();
        logic [47:0] ks [4];
        ks[0] = k0; ks[1] = k1; ks[2] = k2; ks[3] = k3;
        for (int i = 0; i < 4; i++) begin
            do_cmd(2'd0, ks[i], 2'd0, 1'b0, 2'd0, 0);
            expect_rsp("R3", 0, 0, i, row_r);
        end
        chk("R10", "ready after done", longint'(cmd_ready), 1);
        for (int i = 0; i < 4; i++) look("R2", ks[i], CH, 2'd0, 1, 0, i, row_r);
    endtask

    // R4, R7: overflow to CAM; memory copy wins over CAM copy.
    task automatic t_overflow();
        do_cmd(2'd0, k4, 2'd0, 1'b0, 2'd0, 0);
        expect_rsp("R4", 0, 1, 0, 0);
        do_cmd(2'd0, k0, 2'd0, 1'b0, 2'd0, 0);
        expect_rsp("R4", 0, 1, 0, 1);
        look("R4", k4, CH, 2'd0, 1, 1, 0, 0);
        look("R7", k0, CH, 2'd0, 1, 0, 0, row_r);
    endtask

    // R8: delete, repeat delete, reuse.
    task automatic t_delete();
        do_cmd(2'd1, 48'h0, 2'd0, 1'b0, 2'd0, row_r);
        expect_rsp("R8", 0, 0, 0, row_r);
        look("R8", k0, CH, 2'd0, 1, 1, 0, 1);
        do_cmd(2'd1, 48'h0, 2'd0, 1'b0, 2'd0, row_r);
        chk("R8", "second delete status", longint'(got_st), 2);
        do_cmd(2'd0, k5, 2'd0, 1'b0, 2'd0, 0);
        expect_rsp("R8", 0, 0, 0, row_r);
        do_cmd(2'd1, 48'h0, 2'd0, 1'b1, 2'd0, 1);
        chk("R8", "cam delete status", longint'(got_st), 0);
        look("R8", k0, CH, 2'd0, 0, 0, 0, 0);
        do_cmd(2'd1, 48'h0, 2'd0, 1'b1, 2'd0, 40);
        chk("R8", "out of range delete", longint'(got_st), 2);
        do_cmd(2'd3, k0, 2'd0, 1'b0, 2'd0, row_r);
        chk("R10", "reserved op status", longint'(got_st), 2);
        look("R10", k5, CH, 2'd0, 1, 0, 0, row_r);
    endtask

    // R1: channel type ignored under the default mask, matters under a full mask.
    task automatic t_mask();
        look("R1", k1, CH, 2'd3, 1, 0, 1, row_r);
        look("R1", k1, CH + 12'd1, 2'd0, 0, 0, 0, 0);
        key_mask = '1;
        look("R1", k1, CH, 2'd0, 1, 0, 1, row_r);
        look("R1", k1, CH, 2'd3, 0, 0, 0, 0);
        key_mask = DEF_MASK;
    endtask

    // R9: in-place update, refused update, update of empty slot, CAM update.
    task automatic t_update();
        do_cmd(2'd2, k6, 2'd0, 1'b0, 2'd1, row_r);
        expect_rsp("R9", 0, 0, 1, row_r);
        look("R9", k6, CH, 2'd0, 1, 0, 1, row_r);
        look("R9", k1, CH, 2'd0, 0, 0, 0, 0);
        do_cmd(2'd2, k7, 2'd0, 1'b0, 2'd1, row_r);
        chk("R9", "mismatch status", longint'(got_st), 3);
        look("R9", k6, CH, 2'd0, 1, 0, 1, row_r);
        look("R9", k7, CH, 2'd0, 0, 0, 0, 0);
        do_cmd(2'd2, k7, 2'd0, 1'b0, 2'd2, (row_r + 1) % ROWS);
        chk("R9", "empty update status", longint'(got_st), 2);
        do_cmd(2'd2, k7, 2'd0, 1'b1, 2'd0, 0);
        chk("R9", "cam update status", longint'(got_st), 0);
        look("R9", k7, CH, 2'd0, 1, 1, 0, 0);
        look("R9", k4, CH, 2'd0, 0, 0, 0, 0);
    endtask

    // R4, R5: fill the CAM slot by slot, then run out of space.
    task automatic t_full();
        logic [47:0] m;
        for (int s = 1; s < 32; s++) begin
            seek(row_r, 1'b1, m);
            do_cmd(2'd0, m, 2'd0, 1'b0, 2'd0, 0);
            if (s == 1 || s == 31) expect_rsp("R4", 0, 1, 0, s);
            else chk("R4", "cam fill index", longint'(got_idx), s);
        end
        seek(row_r, 1'b1, m);
        do_cmd(2'd0, m, 2'd0, 1'b0, 2'd0, 0);
        chk("R5", "no space status", longint'(got_st), 1);
        look("R5", m, CH, 2'd0, 0, 0, 0, 0);
        seek(row_r, 1'b0, m);
        do_cmd(2'd0, m, 2'd0, 1'b0, 2'd0, 0);
        expect_rsp("R5", 0, 0, 0, ref_row(m, CH, 2'd0, DEF_MASK));
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        k0 = cursor;
        row_r = ref_row(k0, CH, 2'd0, DEF_MASK);
        seek(row_r, 1'b1, k1);
        seek(row_r, 1'b1, k2);
        seek(row_r, 1'b1, k3);
        seek(row_r, 1'b1, k4);
        seek(row_r, 1'b1, k5);
        seek(row_r, 1'b1, k6);
        seek(row_r, 1'b0, k7);
        kx = k7;
        t_reset();
        t_fill();
        t_overflow();
        t_delete();
        t_mask();
        t_update();
        t_full();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule